// File: doc/BRIEF.md
# Machine-Cycle Timer/Counter with Edge Capture

This block is a 16-bit up-counter made of two 8-bit lanes. It counts one of two things. In timer function it counts machine cycles, where one machine cycle is a fixed number of core clocks (12 by default). In counter function it counts falling edges on an external count input. That input is synchronised and then sampled once per machine cycle. An edge is found when one sample reads high and the next sample reads low.

A second external input, the capture input, goes through the same sampling path. When capture is enabled, a falling edge on it copies the running count into a 16-bit capture register and sets an external-event flag. A count wrap from 0xFFFF to 0x0000 sets an overflow flag. Either flag raises the interrupt output, and both flags stay set until software writes them back to zero.

Software reaches the block through a small write port. Address 0 is the control byte, address 1 is the count low byte and address 2 is the count high byte. The control byte, count and capture value are visible on output ports at all times.

Top module: `capture_timer16`

## Requirements
- R1: The count changes only by software write unless run (control bit 0) is 1, capture select (bit 2) is 1 and both baud selects (bits 4 and 5) are 0. A write of 0 to bit 0 stops counting, and so does any other combination of these bits.
- R2: In timer function (control bit 1 = 0) with counting enabled, the count rises by exactly 1 once every OSC_PER_MC (12) clocks.
- R3: In counter function (control bit 1 = 1) with counting enabled, each low-then-high pulse on `cnt_pin`, with each level held at least one machine cycle, adds exactly 1 to the count. The carry passes from the low lane into the high lane.
- R4: A falling edge on a pin is seen at the machine-cycle sample that first reads low. The matching update happens at the next machine-cycle strobe, 12 clocks later. The pin reaches the sampler through SYNC_STAGES (2) clock flops.
- R5: A count wrap from 0xFFFF to 0x0000 sets the overflow flag (control bit 6). The flag stays set until a control write puts 0 there. `irq` is 1 whenever bit 6 or bit 7 is 1.
- R6: With ext-enable (control bit 3) = 1 and capture select = 1 with baud selects 0, a falling edge on `cap_pin` copies the count into `cap_o`. It also sets the external flag (control bit 7), which stays set until cleared by a control write. This happens whatever the run bit is.
- R7: With ext-enable = 0, edges on `cap_pin` leave `cap_o` and control bit 7 unchanged.
- R8: A write to the count low byte (address 1) or high byte (address 2) takes priority over an increment in the same clock. The written byte is loaded, the other byte is kept, and that increment is lost.
- R9: After reset the count, the capture value, the control byte and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 count low byte, 2 count high byte |
| wr_data | input | 8 | Write data |
| cnt_pin | input | 1 | External count input (falling edges counted) |
| cap_pin | input | 1 | External capture input |
| ctrl_o | output | 8 | Control byte including both flags |
| count_o | output | 16 | Current count |
| cap_o | output | 16 | Last captured count |
| irq | output | 1 | Interrupt request (either flag set) |

## Verification
A write shows on the outputs one clock after the edge that takes it. A timer increment shows one clock after a machine-cycle strobe. A pin edge takes effect one full machine cycle after the strobe whose sample first reads low, and that strobe lags the pin by the two synchroniser clocks. The table tests hold every pin level for a full machine cycle. They then wait three machine cycles before reading results, so the strobe phase does not matter. The exact-timing tests first locate the strobe phase from a timer increment. They then place pin changes and writes at fixed clock offsets from that strobe and sample at the clock where each result is due and at the clock just before it.

// File: rtl/ct16_pkg.sv
package ct16_pkg;

  localparam int LANE_W  = 8;
  localparam int LANES   = 2;
  localparam int COUNT_W = LANE_W * LANES;

  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_CNT_LO = 2'd1,
    ADDR_CNT_HI = 2'd2,
    ADDR_RSVD   = 2'd3
  } reg_addr_e;

  // First member is the most significant bit.
  typedef struct packed {
    logic ext_flag;  // bit 7
    logic ovf_flag;  // bit 6
    logic baud_b;    // bit 5
    logic baud_a;    // bit 4
    logic ext_en;    // bit 3
    logic cap_sel;   // bit 2
    logic cnt_sel;   // bit 1
    logic run;       // bit 0
  } ctrl_t;

endpackage

// File: rtl/ct16_mc_strobe.sv
module ct16_mc_strobe #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] div_q, div_d;

  assign tick_o = (div_q == LAST);

  always_comb begin
    div_d = div_q + CNT_W'(1);
    if (tick_o) begin
      div_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

endmodule

// File: rtl/ct16_fall_sampler.sv
module ct16_fall_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic pin_i,
  output logic fall_o
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic smp_new_q, smp_new_d;
  logic smp_old_q, smp_old_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb sync_d = pin_i;
    end else begin : g_chain
      always_comb sync_d = {sync_q[SYNC_STAGES-2:0], pin_i};
    end
  endgenerate

  always_comb begin
    smp_new_d = smp_new_q;
    smp_old_d = smp_old_q;
    if (tick_i) begin
      smp_new_d = sync_q[SYNC_STAGES-1];
      smp_old_d = smp_new_q;
    end
  end

  // Held between strobes: old sample high, newest sample low.
  assign fall_o = smp_old_q & ~smp_new_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= '1;
      smp_new_q <= 1'b1;
      smp_old_q <= 1'b1;
    end else begin
      sync_q    <= sync_d;
      smp_new_q <= smp_new_d;
      smp_old_q <= smp_old_d;
    end
  end

endmodule

// File: rtl/ct16_count_core.sv
module ct16_count_core #(
  parameter int LANE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      inc_i,
  input  logic [LANES-1:0]          wr_lane_i,
  input  logic [LANE_W-1:0]         wr_data_i,
  output logic [LANE_W*LANES-1:0]   count_o,
  output logic                      wrap_o
);

  localparam logic [LANE_W-1:0] ONES = '1;

  logic             inc_ok;
  logic [LANES:0]   carry;

  // Any software write to the count cancels this cycle's increment.
  assign inc_ok   = inc_i & ~(|wr_lane_i);
  assign carry[0] = inc_ok;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] lane_q, lane_d;

      assign carry[g+1] = carry[g] & (lane_q == ONES);

      always_comb begin
        lane_d = lane_q;
        if (wr_lane_i[g]) begin
          lane_d = wr_data_i;
        end else if (carry[g]) begin
          lane_d = lane_q + LANE_W'(1);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lane_q <= '0;
        end else begin
          lane_q <= lane_d;
        end
      end

      assign count_o[g*LANE_W +: LANE_W] = lane_q;
    end
  endgenerate

  assign wrap_o = carry[LANES];

endmodule

// File: rtl/capture_timer16.sv
module capture_timer16
  import ct16_pkg::*;
#(
  parameter int OSC_PER_MC  = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [7:0]   wr_data,
  input  logic         cnt_pin,
  input  logic         cap_pin,
  output logic [7:0]   ctrl_o,
  output logic [15:0]  count_o,
  output logic [15:0]  cap_o,
  output logic         irq
);

  // Reset: asynchronous assertion, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic tick;
  logic cnt_fall;
  logic cap_fall;

  ct16_mc_strobe #(.DIV(OSC_PER_MC)) u_strobe (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick_o (tick)
  );

  ct16_fall_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_cnt_smp (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick_i (tick),
    .pin_i  (cnt_pin),
    .fall_o (cnt_fall)
  );

  ct16_fall_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_cap_smp (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick_i (tick),
    .pin_i  (cap_pin),
    .fall_o (cap_fall)
  );

  ctrl_t              ctrl_q, ctrl_d;
  logic [COUNT_W-1:0] cap_q, cap_d;
  logic [COUNT_W-1:0] count;
  logic [LANES-1:0]   wr_lane;
  logic               wr_ctrl;
  logic               cap_mode;
  logic               counting;
  logic               inc;
  logic               wrap;
  logic               cap_evt;

  assign wr_ctrl    = wr_en & (reg_addr_e'(wr_addr) == ADDR_CTRL);
  assign wr_lane[0] = wr_en & (reg_addr_e'(wr_addr) == ADDR_CNT_LO);
  assign wr_lane[1] = wr_en & (reg_addr_e'(wr_addr) == ADDR_CNT_HI);

  assign cap_mode = ctrl_q.cap_sel & ~ctrl_q.baud_a & ~ctrl_q.baud_b;
  assign counting = ctrl_q.run & cap_mode;
  assign inc      = tick & counting & (ctrl_q.cnt_sel ? cnt_fall : 1'b1);
  assign cap_evt  = tick & cap_fall & cap_mode & ctrl_q.ext_en;

  ct16_count_core #(.LANE_W(LANE_W), .LANES(LANES)) u_core (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .inc_i     (inc),
    .wr_lane_i (wr_lane),
    .wr_data_i (wr_data),
    .count_o   (count),
    .wrap_o    (wrap)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d = ctrl_t'(wr_data);
    end
    // A hardware event wins over a software clear in the same clock.
    if (wrap) begin
      ctrl_d.ovf_flag = 1'b1;
    end
    if (cap_evt) begin
      ctrl_d.ext_flag = 1'b1;
    end
  end

  always_comb begin
    cap_d = cap_q;
    if (cap_evt) begin
      cap_d = count;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_q <= '0;
      cap_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      cap_q  <= cap_d;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign count_o = count;
  assign cap_o   = cap_q;
  assign irq     = ctrl_q.ovf_flag | ctrl_q.ext_flag;

endmodule

// File: rtl/ct16_checker.sv
module ct16_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [7:0]  ctrl_o,
  input logic [15:0] count_o,
  input logic [15:0] cap_o
);

  // R1: stopped count stays put without a write
  p_stop_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_o[0] && !wr_en) |=> $stable(count_o));

  // R2/R3: without a write the count moves by at most one step
  p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (count_o == $past(count_o) || count_o == $past(count_o) + 16'd1));

  // R5: leaving 0xFFFF without a write raises the overflow flag
  p_wrap_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == 16'hFFFF && !wr_en) |=> (count_o == 16'hFFFF || ctrl_o[6]));

  // R6: a new capture value equals the count of the previous clock
  p_cap_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_o != $past(cap_o)) |-> (cap_o == $past(count_o)));

  // R7: capture path silent while ext-enable is clear
  p_cap_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_o[3] && !wr_en) |=> ($stable(cap_o) && ctrl_o[7] == $past(ctrl_o[7])));

endmodule

bind capture_timer16 ct16_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .ctrl_o  (ctrl_o),
  .count_o (count_o),
  .cap_o   (cap_o)
);

// File: tb/sim_capture_timer16.sv
`timescale 1ns/1ps
module sim_capture_timer16;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [7:0]  wr_data;
  logic        cnt_pin;
  logic        cap_pin;
  logic [7:0]  ctrl_o;
  logic [15:0] count_o;
  logic [15:0] cap_o;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  capture_timer16 u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_pin(cnt_pin), .cap_pin(cap_pin),
    .ctrl_o(ctrl_o), .count_o(count_o), .cap_o(cap_o), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [15:0] start;
    logic [3:0]  pulses;
    logic [15:0] exp_cnt;
    logic        exp_ovf;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'h07, 16'h0000, 4'd3, 16'h0003, 1'b0},  // R3 plain count
    '{8'h07, 16'h00FF, 4'd2, 16'h0101, 1'b0},  // R3 lane carry
    '{8'h07, 16'hFFFE, 4'd3, 16'h0001, 1'b1},  // R5 wrap
    '{8'h06, 16'h1234, 4'd3, 16'h1234, 1'b0},  // R1 run clear
    '{8'h17, 16'h1234, 4'd2, 16'h1234, 1'b0},  // R1 baud select set
    '{8'h03, 16'h4321, 4'd2, 16'h4321, 1'b0},  // R1 capture select clear
    '{8'h0F, 16'h00FE, 4'd2, 16'h0100, 1'b0}   // R3 with ext-enable
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_count(input logic [15:0] v);
    wr(2'd1, v[7:0]);
    wr(2'd2, v[15:8]);
  endtask

  task automatic cnt_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      cnt_pin = 1'b0; repeat (12) @(negedge clk);
      cnt_pin = 1'b1; repeat (12) @(negedge clk);
    end
    repeat (36) @(negedge clk);
  endtask

  task automatic cap_pulse();
    cap_pin = 1'b0; repeat (12) @(negedge clk);
    cap_pin = 1'b1; repeat (36) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] old;
    logic [7:0]  hi;
    int n;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    cnt_pin = 1'b1; cap_pin = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    check("R9 count", 32'(count_o), 32'h0);
    check("R9 cap",   32'(cap_o),   32'h0);
    check("R9 ctrl",  32'(ctrl_o),  32'h0);
    check("R9 irq",   32'(irq),     32'h0);

    // Table of counter-function cases
    for (int v = 0; v < NV; v++) begin
      wr(2'd0, 8'h00);
      set_count(VECS[v].start);
      wr(2'd0, VECS[v].ctrl);
      repeat (24) @(negedge clk);
      cnt_pulses(int'(VECS[v].pulses));
      check($sformatf("R3/R1 vec%0d count", v), 32'(count_o), 32'(VECS[v].exp_cnt));
      check($sformatf("R5 vec%0d ovf", v), 32'(ctrl_o[6]), 32'(VECS[v].exp_ovf));
      check($sformatf("R5 vec%0d irq", v), 32'(irq), 32'(VECS[v].exp_ovf));
    end

    // R6 capture with ext-enable
    wr(2'd0, 8'h0E);
    set_count(16'h1234);
    repeat (24) @(negedge clk);
    cap_pulse();
    check("R6 cap value", 32'(cap_o), 32'h1234);
    check("R6 ext flag",  32'(ctrl_o[7]), 32'h1);
    check("R6 irq",       32'(irq), 32'h1);

    // R7 capture ignored
    wr(2'd0, 8'h06);
    set_count(16'h2222);
    repeat (24) @(negedge clk);
    cap_pulse();
    check("R7 cap kept", 32'(cap_o), 32'h1234);
    check("R7 no flag",  32'(ctrl_o[7]), 32'h0);
    check("R7 no irq",   32'(irq), 32'h0);

    // R5 sticky overflow flag and software clear
    wr(2'd0, 8'h06);
    set_count(16'hFFFF);
    wr(2'd0, 8'h07);
    repeat (24) @(negedge clk);
    cnt_pulses(1);
    check("R5 wrap count", 32'(count_o), 32'h0);
    check("R5 flag set",   32'(ctrl_o[6]), 32'h1);
    repeat (60) @(negedge clk);
    check("R5 flag sticky", 32'(ctrl_o[6]), 32'h1);
    wr(2'd0, 8'h07);
    check("R5 flag cleared", 32'(ctrl_o[6]), 32'h0);
    check("R5 irq cleared",  32'(irq), 32'h0);

    // R2 timer function: locate the strobe phase
    wr(2'd0, 8'h05);
    old = count_o; n = 0;
    while (count_o == old && n < 40) begin @(negedge clk); n++; end
    check("R2 first step", 32'(count_o), 32'(old + 16'd1));
    old = count_o;
    repeat (11) @(negedge clk);
    check("R2 hold 11 clocks", 32'(count_o), 32'(old));
    @(negedge clk);
    check("R2 step after 12", 32'(count_o), 32'(old + 16'd1));
    // now 12 clocks after strobe P0 -> redefine as P0
    wr(2'd0, 8'h07);                 // counter function, after P1
    repeat (8) @(negedge clk);       // after P9
    cnt_pin = 1'b0;                  // seen low by strobe P12
    old = count_o;
    repeat (14) @(negedge clk);      // after P23
    check("R4 not before next strobe", 32'(count_o), 32'(old));
    @(negedge clk);                  // after P24
    check("R4 update at next strobe", 32'(count_o), 32'(old + 16'd1));
    cnt_pin = 1'b1;
    wr(2'd0, 8'h05);                 // timer function, after P25
    repeat (10) @(negedge clk);      // after P35
    hi = count_o[15:8];
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h5A;
    @(negedge clk);                  // after P36 (strobe and write together)
    wr_en = 1'b0;
    check("R8 write beats increment", 32'(count_o), 32'({hi, 8'h5A}));
    repeat (12) @(negedge clk);      // after P48
    check("R8/R2 counting resumes", 32'(count_o), 32'({hi, 8'h5B}));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule